// File: doc/BRIEF.md
# Boot Image Stream Sender

This block pushes a program image out of a serial line to a remote loader that waits for an unlock key before it accepts code. A single start pulse, together with a word count N, launches one frame. The block sends a fixed ASCII key, then the count as four bytes, then N 32-bit words. It fetches the words itself from a local synchronous memory through a read address port. Its own 8N1 transmitter shifts every byte onto the line at a bit period set by the clock frequency and the baud rate.

The frame is fully determined by N: 13 + 4*N bytes in all. Multi-byte quantities go out least significant byte first, so the receiver can rebuild the count and the words and confirm the byte total. While a frame is in flight the block reports busy, ignores further start pulses, and signals completion with a single-cycle done pulse.

Top module: `boot_stream_tx`

## Requirements
- R1: After reset the serial line is high, busy and done are low, and the memory read address is 0.
- R2: Every frame begins with the key parameter, nine ASCII bytes by default ("LEVELTEST"), first character first, so the first byte on the line is 0x4C.
- R3: The word count follows the key as four bytes, least significant first; N = 257 goes out as 0x01, 0x01, 0x00, 0x00.
- R4: The words follow in address order from word 0, each least significant byte first (0xDEADBEEF goes out as 0xEF, 0xBE, 0xAD, 0xDE); the read address starts at 0, only ever steps up by one or returns to 0, and data is taken one clock after its address.
- R5: A frame of N words carries exactly 13 + 4*N bytes.
- R6: Each byte is framed 8N1: one low start bit, eight data bits least significant first, one high stop bit.
- R7: Every bit cell lasts CLK_HZ / BAUD clocks and consecutive bytes are separated by exactly one idle clock, so done rises 2 + B*(10*CLK_HZ/BAUD + 1) clock edges after the edge before the start pulse is sampled, for a frame of B bytes.
- R8: Whenever busy is low the serial line is high.
- R9: A start pulse while idle raises busy at the next clock edge; a start pulse while busy changes neither the frame in progress nor its count.
- R10: Done is a one-cycle pulse, raised at the same edge where busy falls, one clock after the last stop cell ends.
- R11: With N = 0 the frame is the key followed by four zero bytes, with no memory words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse that launches a frame when idle |
| word_count_i | input | ADDR_W+1 | Number of words N, captured at an accepted start |
| mem_addr_o | output | ADDR_W | Word address of the local image memory |
| mem_rdata_i | input | 32 | Read data, valid one clock after the address |
| txd_o | output | 1 | Serial transmit line, idle high |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle pulse when a frame completes |

## Verification
On every cycle the assertions hold the idle line high whenever busy is low, hold busy high after an accepted start, keep done a single-cycle pulse coinciding with the fall of busy, and restrict the read address to single upward steps or a return to zero. The byte contents and their order (key, little-endian count, little-endian words), the 8N1 framing, the byte total for zero, small and multi-byte counts, the exact frame duration that pins the bit period, and the ignoring of a start pulse mid-frame are only visible through the bench's scenarios, which decode the serial line and compare it with a frame computed from N and the memory contents.

// File: rtl/boot_stream_pkg.sv
package boot_stream_pkg;

  localparam int BYTE_W         = 8;
  localparam int WORD_W         = 32;
  localparam int WORD_BYTES     = WORD_W / BYTE_W;
  localparam int LEN_BYTES      = 4;
  localparam int BITS_PER_FRAME = 10;  // start + 8 data + stop

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY,
    SQ_LEN,
    SQ_DATA,
    SQ_FIN
  } seq_state_t;

endpackage

// File: rtl/bs_baud_timer.sv
module bs_baud_timer #(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);

  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  // Counter is held at zero while idle so every bit cell starts aligned
  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/bs_uart_tx.sv
module bs_uart_tx
  import boot_stream_pkg::*;
#(
  parameter int CLKS_PER_BIT = 434
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              ready_o,
  output logic              txd_o,
  output logic              sent_o
);

  localparam int BIT_CW = $clog2(BITS_PER_FRAME);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BITS_PER_FRAME - 1);

  logic              busy_q;
  logic [BYTE_W:0]   shreg_q;   // data bits then the stop bit
  logic [BIT_CW-1:0] bit_q;
  logic              txd_q;
  logic              sent_q;
  logic              tick;

  bs_baud_timer #(
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .run_i (busy_q),
    .tick_o(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      shreg_q <= '1;
      bit_q   <= '0;
      txd_q   <= 1'b1;
      sent_q  <= 1'b0;
    end else begin
      sent_q <= 1'b0;
      if (!busy_q) begin
        if (load_i) begin
          busy_q  <= 1'b1;
          shreg_q <= {1'b1, data_i};
          bit_q   <= '0;
          txd_q   <= 1'b0;          // start cell begins now
        end
      end else if (tick) begin
        if (bit_q == LAST_BIT) begin
          busy_q <= 1'b0;
          sent_q <= 1'b1;
          txd_q  <= 1'b1;
        end else begin
          txd_q   <= shreg_q[0];
          shreg_q <= {1'b1, shreg_q[BYTE_W:1]};
          bit_q   <= bit_q + 1'b1;
        end
      end
    end
  end

  assign ready_o = !busy_q;
  assign txd_o   = txd_q;
  assign sent_o  = sent_q;

endmodule

// File: rtl/bs_frame_seq.sv
module bs_frame_seq
  import boot_stream_pkg::*;
#(
  parameter int                    KEY_LEN = 9,
  parameter logic [8*KEY_LEN-1:0]  KEY     = "LEVELTEST",
  parameter int                    ADDR_W  = 10,
  parameter int                    CNT_W   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              tx_load_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  input  logic              tx_ready_i,
  input  logic              tx_sent_i,
  output logic              busy_o,
  output logic              done_o
);

  localparam int KW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [KW-1:0] KEY_LAST = KW'(KEY_LEN - 1);
  localparam int BW = $clog2(WORD_BYTES);
  localparam logic [BW-1:0] BYTE_LAST = BW'(WORD_BYTES - 1);

  seq_state_t          state_q;
  logic [KW-1:0]       key_idx_q;
  logic [BW-1:0]       byte_idx_q;
  logic [ADDR_W-1:0]   word_idx_q;
  logic [CNT_W-1:0]    count_q;
  logic [WORD_W-1:0]   word_buf_q;
  logic                busy_q;
  logic                done_q;

  logic [BYTE_W-1:0]   key_bytes [KEY_LEN];
  logic [BYTE_W-1:0]   len_bytes [LEN_BYTES];
  logic [WORD_W-1:0]   len_word;
  logic                send;
  logic                last_word;

  assign len_word = WORD_W'(count_q);

  // Key characters in transmit order: leftmost character of the string first
  for (genvar gi = 0; gi < KEY_LEN; gi++) begin : g_key
    assign key_bytes[gi] = KEY[BYTE_W*(KEY_LEN-1-gi) +: BYTE_W];
  end

  // Count bytes in transmit order: least significant first
  for (genvar gj = 0; gj < LEN_BYTES; gj++) begin : g_len
    assign len_bytes[gj] = len_word[BYTE_W*gj +: BYTE_W];
  end

  assign last_word = (CNT_W'(word_idx_q) == count_q - CNT_W'(1));

  always_comb begin
    case (state_q)
      SQ_KEY:  tx_byte_o = key_bytes[key_idx_q];
      SQ_LEN:  tx_byte_o = len_bytes[byte_idx_q];
      SQ_DATA: tx_byte_o = (byte_idx_q == '0) ? mem_rdata_i[BYTE_W-1:0]
                                             : word_buf_q[BYTE_W*byte_idx_q +: BYTE_W];
      default: tx_byte_o = '0;
    endcase
  end

  assign send = tx_ready_i &&
                ((state_q == SQ_KEY) || (state_q == SQ_LEN) || (state_q == SQ_DATA));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SQ_IDLE;
      key_idx_q  <= '0;
      byte_idx_q <= '0;
      word_idx_q <= '0;
      count_q    <= '0;
      word_buf_q <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            state_q    <= SQ_KEY;
            busy_q     <= 1'b1;
            count_q    <= count_i;
            key_idx_q  <= '0;
            byte_idx_q <= '0;
            word_idx_q <= '0;
          end
        end
        SQ_KEY: begin
          if (send) begin
            if (key_idx_q == KEY_LAST) begin
              state_q    <= SQ_LEN;
              byte_idx_q <= '0;
            end else begin
              key_idx_q <= key_idx_q + 1'b1;
            end
          end
        end
        SQ_LEN: begin
          if (send) begin
            byte_idx_q <= byte_idx_q + 1'b1;
            if (byte_idx_q == BYTE_LAST) begin
              state_q <= (count_q == '0) ? SQ_FIN : SQ_DATA;
            end
          end
        end
        SQ_DATA: begin
          if (send) begin
            if (byte_idx_q == '0) begin
              word_buf_q <= mem_rdata_i;
            end
            byte_idx_q <= byte_idx_q + 1'b1;
            if (byte_idx_q == BYTE_LAST) begin
              if (last_word) begin
                state_q <= SQ_FIN;
              end else begin
                word_idx_q <= word_idx_q + 1'b1;
              end
            end
          end
        end
        SQ_FIN: begin
          if (tx_sent_i) begin
            state_q <= SQ_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign tx_load_o  = send;
  assign mem_addr_o = word_idx_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;

endmodule

// File: rtl/boot_stream_tx.sv
module boot_stream_tx
  import boot_stream_pkg::*;
#(
  parameter int                   CLK_HZ  = 50_000_000,
  parameter int                   BAUD    = 115_200,
  parameter int                   KEY_LEN = 9,
  parameter logic [8*KEY_LEN-1:0] KEY     = "LEVELTEST",
  parameter int                   ADDR_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W:0]   word_count_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int CLKS_PER_BIT = CLK_HZ / BAUD;
  localparam int CNT_W        = ADDR_W + 1;

  logic              tx_load;
  logic [BYTE_W-1:0] tx_byte;
  logic              tx_ready;
  logic              tx_sent;

  bs_frame_seq #(
    .KEY_LEN(KEY_LEN),
    .KEY    (KEY),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .count_i    (word_count_i),
    .mem_addr_o (mem_addr_o),
    .mem_rdata_i(mem_rdata_i),
    .tx_load_o  (tx_load),
    .tx_byte_o  (tx_byte),
    .tx_ready_i (tx_ready),
    .tx_sent_i  (tx_sent),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  bs_uart_tx #(
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) u_tx (
    .clk    (clk),
    .rst    (rst),
    .load_i (tx_load),
    .data_i (tx_byte),
    .ready_o(tx_ready),
    .txd_o  (txd_o),
    .sent_o (tx_sent)
  );

endmodule

// File: rtl/bs_stream_chk.sv
module bs_stream_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              txd_o,
  input logic              busy_o,
  input logic              done_o
);

  // R8
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> txd_o);

  // R9
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10
  done_with_busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr_o) |->
      ((mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)) || (mem_addr_o == '0)));

endmodule

bind boot_stream_tx bs_stream_chk #(
  .ADDR_W(ADDR_W)
) u_stream_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .mem_addr_o(mem_addr_o),
  .txd_o     (txd_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/tb_boot_stream_tx.sv
module tb_boot_stream_tx;

  localparam int CLK_HZ = 50_000_000;
  localparam int BAUD   = 12_500_000;
  localparam int CPB    = CLK_HZ / BAUD;
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [71:0] TB_KEY = "LEVELTEST";

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W:0]   word_count = '0;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_rdata;
  logic              txd;
  logic              busy;
  logic              done;

  logic [31:0] mem [DEPTH];
  logic [7:0]  rx_buf [2048];
  int          rx_cnt = 0;
  int          frame_err = 0;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

  boot_stream_tx #(
    .CLK_HZ(CLK_HZ),
    .BAUD  (BAUD),
    .ADDR_W(ADDR_W)
  ) dut (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .word_count_i(word_count),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata),
    .txd_o       (txd),
    .busy_o      (busy),
    .done_o      (done)
  );

  // Serial line decoder, samples mid-cell on falling clock edges
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        repeat (CPB / 2) @(negedge clk);
        if (txd !== 1'b0) frame_err++;
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = txd;
        end
        repeat (CPB) @(negedge clk);
        if (txd !== 1'b1) frame_err++;
        if (rx_cnt < 2048) rx_buf[rx_cnt] = b;
        rx_cnt++;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int k, input int n);
    logic [31:0] nn;
    nn = n;
    if (k < 9) return TB_KEY[8*(8-k) +: 8];
    else if (k < 13) return nn[8*(k-9) +: 8];
    else return mem[(k-13)/4][8*((k-13)%4) +: 8];
  endfunction

  task automatic launch(input int n, output int c0);
    rx_cnt = 0;
    frame_err = 0;
    @(negedge clk);
    word_count = (ADDR_W+1)'(n);
    start = 1'b1;
    c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9 busy after start", 32'(busy), 32'd1);
  endtask

  task automatic wait_done(input int c0, output int cycles);
    int guard = 0;
    while (done !== 1'b1 && guard < 150000) begin
      @(negedge clk);
      guard++;
    end
    cycles = cyc - c0;
    chk(busy === 1'b0, "R10 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frame(input int n, input int cycles);
    int nb = 13 + 4 * n;
    int bad_key = 0, bad_len = 0, bad_dat = 0;
    int fk = -1, fl = -1, fd = -1;
    chk(rx_cnt == nb, "R5 byte total", 32'(rx_cnt), 32'(nb));
    chk(frame_err == 0, "R6 8N1 framing errors", 32'(frame_err), 32'd0);
    chk(cycles == 2 + nb * (10 * CPB + 1), "R7 frame duration", 32'(cycles),
        32'(2 + nb * (10 * CPB + 1)));
    for (int k = 0; k < nb && k < rx_cnt; k++) begin
      if (rx_buf[k] !== exp_byte(k, n)) begin
        if (k < 9) begin bad_key++; if (fk < 0) fk = k; end
        else if (k < 13) begin bad_len++; if (fl < 0) fl = k; end
        else begin bad_dat++; if (fd < 0) fd = k; end
      end
    end
    chk(bad_key == 0, "R2 key bytes", (fk < 0) ? 32'd0 : 32'(rx_buf[fk]),
        (fk < 0) ? 32'd0 : 32'(exp_byte(fk, n)));
    chk(bad_len == 0, "R3 count bytes", (fl < 0) ? 32'd0 : 32'(rx_buf[fl]),
        (fl < 0) ? 32'd0 : 32'(exp_byte(fl, n)));
    chk(bad_dat == 0, "R4 data bytes", (fd < 0) ? 32'd0 : 32'(rx_buf[fd]),
        (fd < 0) ? 32'd0 : 32'(exp_byte(fd, n)));
  endtask

  task automatic t_reset;
    chk(txd === 1'b1, "R1 line high", 32'(txd), 32'd1);
    chk(busy === 1'b0, "R1 busy low", 32'(busy), 32'd0);
    chk(done === 1'b0, "R1 done low", 32'(done), 32'd0);
    chk(mem_addr === '0, "R1 address zero", 32'(mem_addr), 32'd0);
  endtask

  task automatic t_three_words;
    int c0, cyc_n;
    launch(3, c0);
    wait_done(c0, cyc_n);
    check_frame(3, cyc_n);
    chk(rx_buf[0] === 8'h4C, "R2 first byte", 32'(rx_buf[0]), 32'h4C);
    chk({rx_buf[13], rx_buf[14], rx_buf[15], rx_buf[16]} === 32'hEFBEADDE,
        "R4 word0 order", {rx_buf[13], rx_buf[14], rx_buf[15], rx_buf[16]}, 32'hEFBEADDE);
  endtask

  task automatic t_idle_line;
    int low = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) low++;
    end
    chk(low == 0, "R8 idle line high", 32'(low), 32'd0);
  endtask

  task automatic t_zero;
    int c0, cyc_n;
    launch(0, c0);
    wait_done(c0, cyc_n);
    check_frame(0, cyc_n);
    chk({rx_buf[9], rx_buf[10], rx_buf[11], rx_buf[12]} === 32'h0, "R11 zero count bytes",
        {rx_buf[9], rx_buf[10], rx_buf[11], rx_buf[12]}, 32'h0);
  endtask

  task automatic t_long;
    int c0, cyc_n;
    launch(257, c0);
    wait_done(c0, cyc_n);
    check_frame(257, cyc_n);
    chk({rx_buf[9], rx_buf[10], rx_buf[11], rx_buf[12]} === 32'h01010000, "R3 count 257",
        {rx_buf[9], rx_buf[10], rx_buf[11], rx_buf[12]}, 32'h01010000);
  endtask

  task automatic t_ignore_start;
    int c0, cyc_n;
    launch(2, c0);
    repeat (100) @(negedge clk);
    word_count = (ADDR_W+1)'(5);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9 busy kept on ignored start", 32'(busy), 32'd1);
    wait_done(c0, cyc_n);
    check_frame(2, cyc_n);
    chk(rx_cnt == 21, "R9 ignored start count", 32'(rx_cnt), 32'd21);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 32'h1357_9BDF ^ (32'(i) * 32'h0101_0103);
    mem[0] = 32'hDEADBEEF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_three_words();
    t_idle_line();
    t_zero();
    t_ignore_start();
    t_long();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule